// File: doc/BRIEF.md
# Paired Single-to-Integer Converter

The block takes a 64-bit register holding two single-precision floating-point values and turns each of them into a signed 32-bit integer. The value in the high word becomes the high result word and the value in the low word becomes the low result word. The two conversions run side by side and are independent. A 2-bit rounding mode controls how fractions are resolved.

A half is invalid when its value cannot be represented: it is infinity, it is a NaN, or it rounds to an integer outside the signed 32-bit range. When trapping is disabled, an invalid half is replaced by the saturated default 0x7FFFFFFF. When trapping is enabled and either half is invalid, the write is withheld. The status flags are reported in both cases, with the flags of the two halves ORed together.

A request is a one-cycle pulse on `start`. The result, the write strobe and the flags are registered and appear on the next cycle.

Top module: `ps2pw_convert`

## Requirements
- R1: A `start` pulse produces `done` high for exactly the following cycle, and `done` is never high otherwise. In that cycle `result[63:32]` is the conversion of `src[63:32]` and `result[31:0]` is the conversion of `src[31:0]`, computed independently.
- R2: A finite value that is already an integer within range converts exactly, as a two's-complement word, with no flag set.
- R3: `rmode` selects the rounding: 0 rounds to nearest with ties to even, 1 truncates toward zero, 2 rounds toward +infinity and 3 rounds toward -infinity.
- R4: A half holding infinity (exponent all ones, fraction zero), a NaN (exponent all ones, fraction nonzero) or a value outside -2^31..2^31-1 raises `flag_inv`. With `inv_en` low, that half of `result` is 0x7FFFFFFF, the other half converts normally, and `wr_en` is high.
- R5: With `inv_en` high and either half invalid, `wr_en` stays low in the `done` cycle while `done` and the flags are still reported. With `inv_en` high and no invalid half, `wr_en` is high.
- R6: `flag_inx` is set when a half that is not invalid discards nonzero fraction bits. The inexact and invalid indications of the two halves are ORed.
- R7: A value of exactly -2^31 is valid and converts to 0x80000000. The value +2^31 is invalid.
- R8: Zero and denormal inputs convert to 0, except that a nonzero denormal converts to +1 under mode 2 when positive and to -1 under mode 3 when negative. A nonzero denormal sets `flag_inx`.
- R9: `flag_ovf` is set only when a finite half is out of range, and it is always accompanied by `flag_inv`. A NaN or an infinity does not set it.
- R10: After reset, `result` is zero and `done`, `wr_en` and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle conversion request |
| src | input | 64 | Two packed single-precision values |
| rmode | input | 2 | Rounding mode select |
| inv_en | input | 1 | Invalid trap enable; suppresses the write on an invalid half |
| result | output | 64 | Two packed signed 32-bit integers |
| done | output | 1 | Result and flags valid this cycle |
| wr_en | output | 1 | Result may be written to the destination |
| flag_inv | output | 1 | Invalid condition in either half |
| flag_inx | output | 1 | Inexact condition in either half |
| flag_ovf | output | 1 | Finite out-of-range value in either half |

## Verification
The hardest cases to reach sit at the edges of the range and the fraction. These are the values exactly at -2^31 and +2^31, the largest representable single below 2^31, rounding ties, and denormals under directed rounding. Each is encoded directly as a hand-computed bit pattern and driven through both halves. Mixed requests are also driven, pairing an invalid half with an inexact half. These show that each flag is ORed across halves while each result word stays independent, and that a trap withholds only the write.

// File: rtl/ps2pw_convert.sv
module ps2pw_convert #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2*W-1:0] src,
  input  logic [1:0]     rmode,
  input  logic           inv_en,
  output logic [2*W-1:0] result,
  output logic           done,
  output logic           wr_en,
  output logic           flag_inv,
  output logic           flag_inx,
  output logic           flag_ovf
);
  localparam int RW = W + 3;
  localparam logic [W-1:0] SAT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [RW-1:0] cvt(input logic [31:0] x, input logic [1:0] rm);
    logic s;
    logic [7:0] e, r;
    logic [22:0] f;
    logic [23:0] m, ig;
    logic [49:0] sh;
    logic rb, st, inc, inv, ovf, inx;
    logic [W-1:0] mag, v;
    s = x[31]; e = x[30:23]; f = x[22:0]; m = {1'b1, f};
    inv = 1'b0; ovf = 1'b0; inx = 1'b0; v = '0; mag = '0;
    ig = '0; rb = 1'b0; st = 1'b0; inc = 1'b0; sh = '0; r = '0;
    if (e == 8'hFF) begin
      inv = 1'b1;
    end else if (e >= 8'd158) begin
      if (e == 8'd158 && s && f == 23'd0) v = MINV;
      else begin inv = 1'b1; ovf = 1'b1; end
    end else if (e >= 8'd150) begin
      mag = {8'b0, m} << (e - 8'd150);
      v = s ? -mag : mag;
    end else begin
      r = 8'd150 - e;
      if (e == 8'd0 || r > 8'd25) begin
        st = (e != 8'd0) || (f != 23'd0);
      end else begin
        sh = {m, 26'b0} >> r;
        ig = sh[49:26];
        rb = sh[25];
        st = |sh[24:0];
      end
      case (rm)
        2'd0: inc = rb & (st | ig[0]);
        2'd1: inc = 1'b0;
        2'd2: inc = ~s & (rb | st);
        default: inc = s & (rb | st);
      endcase
      mag = {8'b0, ig} + {{(W-1){1'b0}}, inc};
      v = s ? -mag : mag;
      inx = rb | st;
    end
    if (inv) v = SAT;
    return {inv, ovf, inx, v};
  endfunction

  logic [RW-1:0] hi_c, lo_c;
  assign hi_c = cvt(src[2*W-1:W], rmode);
  assign lo_c = cvt(src[W-1:0], rmode);

  logic any_inv;
  assign any_inv = hi_c[RW-1] | lo_c[RW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      done     <= 1'b0;
      wr_en    <= 1'b0;
      flag_inv <= 1'b0;
      flag_inx <= 1'b0;
      flag_ovf <= 1'b0;
    end else begin
      done  <= start;
      wr_en <= start & ~(inv_en & any_inv);
      if (start) begin
        result   <= {hi_c[W-1:0], lo_c[W-1:0]};
        flag_inv <= any_inv;
        flag_inx <= hi_c[W] | lo_c[W];
        flag_ovf <= hi_c[W+1] | lo_c[W+1];
      end
    end
  end

  p_done_follows_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_write_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);
  p_trap_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && inv_en && any_inv) |=> (done && !wr_en && flag_inv));
  p_ovf_implies_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> flag_inv);
  p_sat_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hi_c[RW-1]) |=> (result[2*W-1:W] == SAT));
endmodule

// File: tb/ps2pw_convert_tb_top.sv
module ps2pw_convert_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] src = '0;
  logic [1:0] rmode = 2'd0;
  logic inv_en = 1'b0;
  logic [63:0] result;
  logic done, wr_en, flag_inv, flag_inx, flag_ovf;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ps2pw_convert dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src), .rmode(rmode),
    .inv_en(inv_en), .result(result), .done(done), .wr_en(wr_en),
    .flag_inv(flag_inv), .flag_inx(flag_inx), .flag_ovf(flag_ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic conv(input string tag, input logic [31:0] hi, input logic [31:0] lo,
                      input logic [1:0] rm, input logic ie,
                      input logic [31:0] ehi, input logic [31:0] elo,
                      input logic ewr, input logic einv, input logic einx, input logic eovf);
    @(negedge clk);
    src = {hi, lo}; rmode = rm; inv_en = ie; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R1 done"}, {63'd0, done}, 64'd1);
    if (ewr || !ie) chk({tag, " result"}, result, {ehi, elo});
    chk({tag, " R5 wr_en"}, {63'd0, wr_en}, {63'd0, ewr});
    chk({tag, " R4 inv"}, {63'd0, flag_inv}, {63'd0, einv});
    chk({tag, " R6 inx"}, {63'd0, flag_inx}, {63'd0, einx});
    chk({tag, " R9 ovf"}, {63'd0, flag_ovf}, {63'd0, eovf});
    @(negedge clk);
    chk({tag, " R1 done drops"}, {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R10 result", result, 64'd0);
    chk("R10 strobes", {58'd0, done, wr_en, flag_inv, flag_inx, flag_ovf}, 64'd0);
  endtask

  task automatic t_exact;
    conv("R2 1.0/-5.0", 32'h3F800000, 32'hC0A00000, 2'd0, 1'b0, 32'd1, 32'hFFFFFFFB, 1, 0, 0, 0);
    conv("R2 zero/largest", 32'h00000000, 32'h4EFFFFFF, 2'd1, 1'b0, 32'd0, 32'h7FFFFF80, 1, 0, 0, 0);
  endtask

  task automatic t_round;
    conv("R3 rne", 32'h40200000, 32'hC0200000, 2'd0, 1'b0, 32'd2, 32'hFFFFFFFE, 1, 0, 1, 0);
    conv("R3 rz", 32'h40200000, 32'hC0200000, 2'd1, 1'b0, 32'd2, 32'hFFFFFFFE, 1, 0, 1, 0);
    conv("R3 rp", 32'h40200000, 32'hC0200000, 2'd2, 1'b0, 32'd3, 32'hFFFFFFFE, 1, 0, 1, 0);
    conv("R3 rm", 32'h40200000, 32'hC0200000, 2'd3, 1'b0, 32'd2, 32'hFFFFFFFD, 1, 0, 1, 0);
    conv("R3 rne 1.5/100.75", 32'h3FC00000, 32'h42C98000, 2'd0, 1'b0, 32'd2, 32'd101, 1, 0, 1, 0);
    conv("R3 rz 1.5/-0.5", 32'h3FC00000, 32'hBF000000, 2'd1, 1'b0, 32'd1, 32'd0, 1, 0, 1, 0);
    conv("R3 rm -0.5/0.5", 32'hBF000000, 32'h3F000000, 2'd3, 1'b0, 32'hFFFFFFFF, 32'd0, 1, 0, 1, 0);
  endtask

  task automatic t_invalid;
    conv("R4 inf hi", 32'h7F800000, 32'h3F800000, 2'd0, 1'b0, 32'h7FFFFFFF, 32'd1, 1, 1, 0, 0);
    conv("R4 nan lo + R6 inx hi", 32'h3FC00000, 32'h7FC00000, 2'd1, 1'b0, 32'd1, 32'h7FFFFFFF, 1, 1, 1, 0);
    conv("R9 range", 32'h4F800000, 32'h00000000, 2'd0, 1'b0, 32'h7FFFFFFF, 32'd0, 1, 1, 0, 1);
    conv("R5 trap", 32'h3F800000, 32'hFF800000, 2'd0, 1'b1, 32'd0, 32'd0, 0, 1, 0, 0);
    conv("R5 trap clean", 32'h3F800000, 32'hC0A00000, 2'd0, 1'b1, 32'd1, 32'hFFFFFFFB, 1, 0, 0, 0);
  endtask

  task automatic t_limits;
    conv("R7 min int", 32'hCF000000, 32'h4F000000, 2'd0, 1'b0, 32'h80000000, 32'h7FFFFFFF, 1, 1, 0, 1);
    conv("R7 min trap clean", 32'hCF000000, 32'd0, 2'd0, 1'b1, 32'h80000000, 32'd0, 1, 0, 0, 0);
  endtask

  task automatic t_denorm;
    conv("R8 rne", 32'h00000001, 32'h80000001, 2'd0, 1'b0, 32'd0, 32'd0, 1, 0, 1, 0);
    conv("R8 rp", 32'h00000001, 32'h80000001, 2'd2, 1'b0, 32'd1, 32'd0, 1, 0, 1, 0);
    conv("R8 rm", 32'h00000001, 32'h80000001, 2'd3, 1'b0, 32'd0, 32'hFFFFFFFF, 1, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_round();
    t_invalid();
    t_limits();
    t_denorm();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule